// File: doc/BRIEF.md
# Quadrature Counter Timer Channel

This block is one 24-bit counter/timer channel with a 16-bit word-addressed register port. It counts either the edges of a two-phase encoder (with an index input) or a free-running internal tick. A 16-bit mode word selects the clock source and decode multiplier, the direction source, the enable source, what happens at terminal count or on an index edge, how the readout latch is captured, which preload register the data writes target, and how the output pin is formed.

The same channel covers three uses. The first is position tracking from an encoder. The second is a software-fired one-shot, where the capture flag gates its own enable. The third is a pulse train, where the counter reloads alternately from two preload registers and the output follows the current segment. Software writes the preload registers through the low and high data offsets. It reads the count through the same offsets: low word first, then high.

Top module: `qct_channel`

## Requirements
- R1: The count is 24 bits and wraps modulo 2^24. A read at offset 0 returns count bits 15:0. A read at offset 1 returns the latched bits 23:16 in rdata[7:0], with rdata[15:8] zero.
- R2: Mode bit 13 selects how the readout latch is captured. When it is 0, a read at offset 0 returns the live low word and captures the whole count, so a later read at offset 1 returns the captured high bits even if the count has moved. When it is 1, the latch captures on each rising edge of the index input, and a read at offset 0 returns the latched low word.
- R3: A write at offset 1 loads wdata[7:0] into preload bits 23:16. A write at offset 0 loads wdata[15:0] into preload bits 15:0. Mode bit 14 picks the target: 0 for preload 0, 1 for preload 1.
- R4: A write at offset 3 is a command word. Bit 15 clears the count. Bit 14 loads the count from preload 0, and wins when both bits are set. Bit 3 clears the capture flag, and this wins over a terminal count in the same cycle.
- R5: With mode bit 12 at 0, the A/B inputs are decoded as quadrature. The (A,B) sequence 00,10,11,01 counts up and its reverse counts down. A step in which both inputs change is ignored. A, B and index pass through a two-stage synchronizer.
- R6: In quadrature mode, mode bits 10:9 select the multiplier. Value 0 is x1 (one count per A cycle: on A rising when moving up, on A falling when moving down). Value 1 is x2 (every A edge). Values 2 and 3 are x4 (every legal edge).
- R7: With mode bit 12 at 1, mode bit 11 sets the direction (1 = down). Mode bits 10:9 equal to 2 count on each cycle in which tick is high; any other value counts on each synchronized rising edge of A.
- R8: Mode bits 8:7 control enable. Value 0 is always enabled; values 1 and 3 are disabled. Value 2 uses a hardware source chosen by mode bits 6:5: 0 is index high, 1 is index low, 2 is capture flag set, 3 is capture flag clear.
- R9: A down step from count 1 is a terminal count and sets the capture flag. Mode bits 4:2 decide the next count. Value 1 alternates reloads: from preload 1 after a preload-0 segment, and from preload 0 after a preload-1 segment. Value 2 reloads from preload 0. Any other value leaves the count at 0.
- R10: With mode bits 4:2 equal to 4, each rising edge of the index input reloads the count from preload 0.
- R11: out_pin is the capture flag when mode bit 0 is 0. When mode bit 0 is 1, out_pin is high during a preload-0 segment. Mode bit 1 inverts out_pin. A load or clear command starts a preload-0 segment.
- R12: After reset the count, capture flag, mode word and out_pin are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (captures the latch on a low-word read) |
| bus_addr | input | 2 | Offset: 0 low data, 1 high data, 2 mode, 3 command/status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (offset 3 reads {phase, flag} in bits 1:0) |
| enc_a | input | 1 | Encoder phase A / external count clock |
| enc_b | input | 1 | Encoder phase B |
| enc_idx | input | 1 | Encoder index |
| tick | input | 1 | Internal clock enable |
| count_val | output | 24 | Live count |
| cap_flag | output | 1 | Capture flag |
| out_pin | output | 1 | Counter output pin |

## Verification
The bench builds the channel with its default 24-bit count and a two-stage synchronizer, so a short reverse move from zero reaches the 2^24 wraparound directly. It walks the encoder through whole cycles in both directions under each multiplier, including simultaneous A/B changes. It sweeps every pulse width from 1 to 4 against every longer period up to 6, comparing the output pin cycle by cycle with the arithmetic pattern. Small preload values keep one-shot and pulse-train runs to a few cycles each.

// File: rtl/qct_pkg.sv
package qct_pkg;

    localparam int REG_W = 16;

    // register offsets
    localparam logic [1:0] OFS_LO   = 2'd0;
    localparam logic [1:0] OFS_HI   = 2'd1;
    localparam logic [1:0] OFS_MODE = 2'd2;
    localparam logic [1:0] OFS_CMD  = 2'd3;

    // clock select codes
    localparam logic [1:0] CLK_X1 = 2'd0;
    localparam logic [1:0] CLK_X2 = 2'd1;
    localparam logic [1:0] CLK_X4 = 2'd2;   // also the internal tick in software-direction mode

    // reload trigger codes
    localparam logic [2:0] RLD_ALT = 3'd1;
    localparam logic [2:0] RLD_PR0 = 3'd2;
    localparam logic [2:0] RLD_IDX = 3'd4;

    // enable control codes
    localparam logic [1:0] EN_ON = 2'd0;
    localparam logic [1:0] EN_HW = 2'd2;

    // command bit positions
    localparam int CMD_CLEAR = 15;
    localparam int CMD_LOAD  = 14;
    localparam int CMD_UNFLG = 3;

    typedef struct packed {
        logic       rsvd;
        logic       pr_sel;
        logic       latch_idx;
        logic       dir_sw;
        logic       dir_down;
        logic [1:0] clk_sel;
        logic [1:0] en_ctl;
        logic [1:0] en_src;
        logic [2:0] reload;
        logic       out_pol;
        logic       out_src;
    } mode_t;

    // direction of a single legal quadrature step
    function automatic logic quad_up(input logic a_now, input logic b_was);
        return a_now ^ b_was;
    endfunction

endpackage

// File: rtl/qct_sync.sv
module qct_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[0] <= '0;
                    else     pipe[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[g] <= '0;
                    else     pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= pipe[STAGES-1];
    end

    assign cur = pipe[STAGES-1];
endmodule

// File: rtl/qct_decode.sv
module qct_decode
    import qct_pkg::*;
(
    input  logic       a_now,
    input  logic       b_now,
    input  logic       a_was,
    input  logic       b_was,
    input  logic       tick,
    input  logic       dir_sw,
    input  logic       dir_down,
    input  logic [1:0] clk_sel,
    output logic       step,
    output logic       up
);
    logic chg_a, chg_b, a_only, one_chg, q_up;

    always_comb begin
        chg_a   = a_now ^ a_was;
        chg_b   = b_now ^ b_was;
        a_only  = chg_a & ~chg_b;
        one_chg = chg_a ^ chg_b;
        q_up    = quad_up(a_now, b_was);
        if (dir_sw) begin
            up   = ~dir_down;
            step = (clk_sel == CLK_X4) ? tick : (a_now & ~a_was);
        end else begin
            up = q_up;
            case (clk_sel)
                CLK_X1:  step = a_only & (q_up == a_now);
                CLK_X2:  step = a_only;
                default: step = one_chg;
            endcase
        end
    end
endmodule

// File: rtl/qct_core.sv
module qct_core
    import qct_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       en_ctl,
    input  logic [1:0]       en_src,
    input  logic [2:0]       reload,
    input  logic             pr_sel,
    input  logic             step,
    input  logic             up,
    input  logic             idx_lvl,
    input  logic             idx_rise,
    input  logic             pr_wr_lo,
    input  logic             pr_wr_hi,
    input  logic             cmd_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic             flag,
    output logic             phase
);
    localparam int HI_W = CNT_W - REG_W;

    logic [CNT_W-1:0] pr [2];
    logic en, go, tc;

    always_comb begin
        case (en_ctl)
            EN_ON: en = 1'b1;
            EN_HW: begin
                case (en_src)
                    2'd0:    en = idx_lvl;
                    2'd1:    en = ~idx_lvl;
                    2'd2:    en = flag;
                    default: en = ~flag;
                endcase
            end
            default: en = 1'b0;
        endcase
        go = step & en;
        tc = go & ~up & (count == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pr[0] <= '0;
            pr[1] <= '0;
        end else begin
            if (pr_wr_hi) pr[pr_sel][CNT_W-1:REG_W] <= wdata[HI_W-1:0];
            if (pr_wr_lo) pr[pr_sel][REG_W-1:0]     <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            phase <= 1'b0;
        end else if (cmd_wr && wdata[CMD_LOAD]) begin
            count <= pr[0];
            phase <= 1'b0;
        end else if (cmd_wr && wdata[CMD_CLEAR]) begin
            count <= '0;
            phase <= 1'b0;
        end else if (reload == RLD_IDX && idx_rise) begin
            count <= pr[0];
            phase <= 1'b0;
        end else if (tc) begin
            if (reload == RLD_ALT) begin
                count <= phase ? pr[0] : pr[1];
                phase <= ~phase;
            end else if (reload == RLD_PR0) begin
                count <= pr[0];
            end else begin
                count <= '0;
            end
        end else if (go) begin
            count <= up ? count + CNT_W'(1) : count - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                          flag <= 1'b0;
        else if (cmd_wr && wdata[CMD_UNFLG]) flag <= 1'b0;
        else if (tc)                      flag <= 1'b1;
    end
endmodule

// File: rtl/qct_channel.sv
module qct_channel
    import qct_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [15:0]      bus_wdata,
    output logic [15:0]      bus_rdata,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_idx,
    input  logic             tick,
    output logic [CNT_W-1:0] count_val,
    output logic             cap_flag,
    output logic             out_pin
);
    mode_t            mode_q;
    logic [CNT_W-1:0] latch_q;
    logic [2:0]       s_cur, s_prev;
    logic             step, up, phase, idx_rise;

    always_ff @(posedge clk) begin
        if (rst)                                 mode_q <= '0;
        else if (bus_wr && bus_addr == OFS_MODE) mode_q <= mode_t'(bus_wdata);
    end

    qct_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({enc_idx, enc_b, enc_a}),
        .cur (s_cur),
        .prev(s_prev)
    );

    assign idx_rise = s_cur[2] & ~s_prev[2];

    qct_decode u_dec (
        .a_now   (s_cur[0]),
        .b_now   (s_cur[1]),
        .a_was   (s_prev[0]),
        .b_was   (s_prev[1]),
        .tick    (tick),
        .dir_sw  (mode_q.dir_sw),
        .dir_down(mode_q.dir_down),
        .clk_sel (mode_q.clk_sel),
        .step    (step),
        .up      (up)
    );

    qct_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .en_ctl  (mode_q.en_ctl),
        .en_src  (mode_q.en_src),
        .reload  (mode_q.reload),
        .pr_sel  (mode_q.pr_sel),
        .step    (step),
        .up      (up),
        .idx_lvl (s_cur[2]),
        .idx_rise(idx_rise),
        .pr_wr_lo(bus_wr && bus_addr == OFS_LO),
        .pr_wr_hi(bus_wr && bus_addr == OFS_HI),
        .cmd_wr  (bus_wr && bus_addr == OFS_CMD),
        .wdata   (bus_wdata),
        .count   (count_val),
        .flag    (cap_flag),
        .phase   (phase)
    );

    // readout latch: captured by a low-word read, or by the index edge
    always_ff @(posedge clk) begin
        if (rst)
            latch_q <= '0;
        else if (!mode_q.latch_idx && bus_rd && bus_addr == OFS_LO)
            latch_q <= count_val;
        else if (mode_q.latch_idx && idx_rise)
            latch_q <= count_val;
    end

    always_comb begin
        case (bus_addr)
            OFS_LO:   bus_rdata = mode_q.latch_idx ? latch_q[REG_W-1:0] : count_val[REG_W-1:0];
            OFS_HI:   bus_rdata = REG_W'(latch_q[CNT_W-1:REG_W]);
            OFS_MODE: bus_rdata = mode_q;
            default:  bus_rdata = {14'd0, phase, cap_flag};
        endcase
    end

    assign out_pin = (mode_q.out_src ? ~phase : cap_flag) ^ mode_q.out_pol;
endmodule

// File: rtl/qct_checker.sv
module qct_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [15:0]      bus_wdata,
    input logic [15:0]      bus_rdata,
    input logic [15:0]      mode_bits,
    input logic [CNT_W-1:0] count_val,
    input logic             cap_flag
);
    localparam int HI_W = CNT_W - 16;

    logic cmd_wr;
    assign cmd_wr = bus_wr && bus_addr == 2'd3;

    AST_HI_PAD: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd1) |-> (bus_rdata[15:HI_W] == '0)); // R1

    AST_CLEAR_CMD: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && bus_wdata[15] && !bus_wdata[14]) |=> (count_val == '0)); // R4

    AST_UNFLAG_CMD: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && bus_wdata[3]) |=> !cap_flag); // R4

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_bits[8:7] == 2'd1 && mode_bits[4:2] != 3'd4 && !cmd_wr) |=> $stable(count_val)); // R8

    AST_TC_FLAG: assert property (@(posedge clk) disable iff (rst)
        (count_val == '0 && $past(count_val) == CNT_W'(1) && !$past(cmd_wr)
         && $past(mode_bits[4:2]) != 3'd4) |-> cap_flag); // R9
endmodule

bind qct_channel qct_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .mode_bits(mode_q),
    .count_val(count_val),
    .cap_flag (cap_flag)
);

// File: tb/sim_qct_channel.sv
module sim_qct_channel;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [15:0]   bus_wdata = 16'd0;
    logic [15:0]   bus_rdata;
    logic          enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0, tick = 1'b0;
    logic [CW-1:0] count_val;
    logic          cap_flag, out_pin;

    int n_chk = 0;
    int n_err = 0;
    int qidx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qct_channel #(.CNT_W(CW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .enc_a(enc_a), .enc_b(enc_b),
        .enc_idx(enc_idx), .tick(tick), .count_val(count_val), .cap_flag(cap_flag),
        .out_pin(out_pin)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // write a preload register; mode word m is restored afterwards
    task automatic set_pr(input logic [15:0] m, input logic sel, input logic [23:0] v);
        wr(2'd2, sel ? (m | 16'h4000) : (m & 16'hBFFF));
        wr(2'd1, {8'd0, v[23:16]});
        wr(2'd0, v[15:0]);
        wr(2'd2, m);
    endtask

    function automatic logic [1:0] qstate(input int i);
        case (i)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    task automatic quad_move(input int n, input bit fwd);
        for (int i = 0; i < n; i++) begin
            qidx = fwd ? (qidx + 1) % 4 : (qidx + 3) % 4;
            @(negedge clk);
            {enc_a, enc_b} = qstate(qidx);
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pulse_idx();
        @(negedge clk);
        enc_idx = 1'b1;
        repeat (4) @(negedge clk);
        enc_idx = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_err++;
        $display("FAIL R12 watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [15:0] mode;
        int          k;
        int          exp_c;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        chk("R12 count", 32'(count_val), 32'd0);
        chk("R12 flag", 32'(cap_flag), 32'd0);
        chk("R12 pin", 32'(out_pin), 32'd0);
        rd(2'd2, d);
        chk("R12 mode", 32'(d), 32'd0);

        // R3 R4 preloads and commands
        set_pr(16'h0000, 1'b0, 24'h123456);
        set_pr(16'h0000, 1'b1, 24'hABCDEF);
        wr(2'd3, 16'h4000);
        chk("R3 R4 load pr0", 32'(count_val), 32'h123456);
        // R1 R2 latch on read, coherent high word
        rd(2'd0, d);
        chk("R1 low word", 32'(d), 32'h3456);
        wr(2'd3, 16'h8000);
        chk("R4 clear", 32'(count_val), 32'd0);
        rd(2'd1, d);
        chk("R2 high from latch", 32'(d), 32'h0012);
        wr(2'd3, 16'hC000);
        chk("R4 load beats clear", 32'(count_val), 32'h123456);
        // R3 preload 1 reached through the alternate reload
        set_pr(16'h1C04, 1'b0, 24'd1);
        wr(2'd3, 16'h4008);
        ticks(1);
        chk("R3 R9 pr1 reload", 32'(count_val), 32'hABCDEF);

        // R5 R6 quadrature sweep per multiplier, including wrap below zero
        for (int m = 0; m < 3; m++) begin
            int fac;
            fac = (m == 0) ? 1 : (m == 1) ? 2 : 4;
            wr(2'd2, 16'(m << 9));
            wr(2'd3, 16'h8000);
            quad_move(20, 1'b1);
            chk($sformatf("R5 R6 fwd x%0d", fac), 32'(count_val), 32'(5 * fac));
            quad_move(28, 1'b0);
            exp_c = (-2 * fac) & 24'hFFFFFF;
            chk($sformatf("R1 R6 wrap x%0d", fac), 32'(count_val), 32'(exp_c));
        end
        // R5 simultaneous change ignored (x4, qidx back at 0)
        wr(2'd3, 16'h8000);
        @(negedge clk); {enc_a, enc_b} = 2'b11; repeat (4) @(negedge clk);
        @(negedge clk); {enc_a, enc_b} = 2'b00; repeat (4) @(negedge clk);
        chk("R5 illegal step", 32'(count_val), 32'd0);

        // R7 software direction, internal tick then external A edges
        wr(2'd2, 16'h1400);
        ticks(10);
        chk("R7 tick up", 32'(count_val), 32'd10);
        wr(2'd2, 16'h1C00);
        ticks(3);
        chk("R7 tick down", 32'(count_val), 32'd7);
        wr(2'd2, 16'h1000);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); enc_a = 1'b1; repeat (4) @(negedge clk);
            enc_a = 1'b0; repeat (4) @(negedge clk);
        end
        chk("R7 ext edges", 32'(count_val), 32'd11);

        // R8 enable control
        wr(2'd2, 16'h1480);
        ticks(5);
        chk("R8 disabled", 32'(count_val), 32'd11);
        wr(2'd2, 16'h1500);
        ticks(5);
        chk("R8 idx low blocks", 32'(count_val), 32'd11);
        @(negedge clk); enc_idx = 1'b1; repeat (4) @(negedge clk);
        ticks(5);
        chk("R8 idx high runs", 32'(count_val), 32'd16);
        wr(2'd2, 16'h1520);
        ticks(2);
        chk("R8 idx inverted", 32'(count_val), 32'd16);
        @(negedge clk); enc_idx = 1'b0; repeat (4) @(negedge clk);

        // R9 R11 one-shot: gated by inverted flag, pin inverted
        mode = 16'h1D62;
        wr(2'd2, mode);
        set_pr(mode, 1'b0, 24'd6);
        wr(2'd3, 16'h4008);
        chk("R11 idle pin", 32'(out_pin), 32'd1);
        ticks(3);
        chk("R9 one-shot mid", 32'(count_val), 32'd3);
        ticks(3);
        chk("R9 one-shot end", 32'(count_val), 32'd0);
        chk("R9 flag set", 32'(cap_flag), 32'd1);
        chk("R11 pin inverted", 32'(out_pin), 32'd0);
        ticks(4);
        chk("R8 flag gate holds", 32'(count_val), 32'd0);

        // R9 R11 pulse train sweep
        mode = 16'h1C05;
        for (int w = 1; w <= 4; w++) begin
            for (int p = w + 1; p <= 6; p++) begin
                int bad;
                bad = 0;
                set_pr(mode, 1'b0, 24'(w));
                set_pr(mode, 1'b1, 24'(p - w));
                wr(2'd3, 16'h4008);
                @(negedge clk);
                tick = 1'b1;
                for (k = 0; k < 2 * p; k++) begin
                    if (out_pin !== (((k % p) < w) ? 1'b1 : 1'b0)) bad++;
                    @(negedge clk);
                end
                tick = 1'b0;
                chk($sformatf("R9 R11 train w%0d p%0d", w, p), 32'(bad), 32'd0);
            end
        end

        // R10 index reload
        mode = 16'h0010;
        wr(2'd2, mode);
        set_pr(mode, 1'b0, 24'h000100);
        wr(2'd3, 16'h8000);
        pulse_idx();
        chk("R10 index reload", 32'(count_val), 32'h100);

        // R2 index-latch mode
        mode = 16'h2000;
        wr(2'd2, mode);
        set_pr(mode, 1'b0, 24'h0A0B0C);
        wr(2'd3, 16'h4000);
        pulse_idx();
        wr(2'd3, 16'h8000);
        rd(2'd0, d);
        chk("R2 idx latch low", 32'(d), 32'h0B0C);
        rd(2'd1, d);
        chk("R2 R1 idx latch high", 32'(d), 32'h000A);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule